// File: doc/BRIEF.md
# Token-Passing Critical Path Analyzer

This block decides online whether a chosen dynamic instruction lies on the critical path of execution. It does this without building the dependence graph. Each instruction in the reorder buffer has three nodes: fetch (F), execute (E) and commit (C). A request places a token on one node of one reorder-buffer entry. As instructions retire, the core reports their last-arriving dependence edges. Each reported edge copies the token bit of its producer node onto its consumer node. The token therefore spreads only along chains of last-arriving edges.

A token bit is lost when its entry is reallocated. When a fixed observation window has elapsed, the block checks whether any bit of the token is still set. A surviving token marks the planted instruction as critical. The block then emits a one-cycle training update carrying the planted PC and the verdict, for use by a criticality prediction table.

Several tokens may be in flight at once. Each one lives in its own replicated 3-bit-per-entry array, called a lane. At the default sizes of 128 entries and 2 lanes the token storage is 768 bits, which is 96 bytes.

Top module: `crit_token_analyzer`

## Requirements
- R1: After reset, `plant_ready` is 1, `train_valid` is 0 and every token bit of every lane is clear.
- R2: A plant is accepted when `plant_valid` is 1, `plant_ready` is 1 and `plant_node` is a valid node code. The node codes are F=0, E=1 and C=2. An accepted plant sets exactly the bit of the chosen node of entry `plant_idx` in one idle lane. A plant with node code 3 is ignored.
- R3: While a lane holds a token, each valid edge writes the consumer node's bit to the value the producer node's bit had at the start of that cycle. A consumer whose producer holds no token is therefore cleared. An edge with node code 3 on either end is ignored.
- R4: `alloc_valid` clears all three bits of entry `alloc_idx` in every lane. If an edge writes a bit of that same entry in the same cycle, the edge's value is the one stored.
- R5: `train_valid` pulses for exactly one cycle, WINDOW clock cycles after the edge on which the plant was accepted. `train_pc` then equals the planted PC, and `train_critical` is 1 exactly when some bit of that lane was still set. Edges and allocations up to the cycle before that expiry edge count toward the verdict.
- R6: Each lane holds one token at a time. `plant_ready` is 0 when all NUM_TOKENS lanes are busy, and a plant presented then has no effect.
- R7: Lanes are independent. An edge copies each lane's own producer bit, so the verdict of one token is not influenced by another token.
- R8: On expiry a lane clears all its bits and becomes idle. `plant_ready` returns to 1 on the next cycle, and a later token in that lane starts from an empty array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| plant_valid | input | 1 | Request to plant a token |
| plant_idx | input | IDX_W | Reorder-buffer entry of the planted instruction |
| plant_node | input | 2 | Node to plant in (F=0, E=1, C=2) |
| plant_pc | input | PC_W | PC of the planted instruction |
| plant_ready | output | 1 | At least one lane is idle |
| edge_valid | input | 1 | A last-arriving edge is reported |
| edge_src_idx | input | IDX_W | Producer entry |
| edge_src_node | input | 2 | Producer node code |
| edge_dst_idx | input | IDX_W | Consumer entry |
| edge_dst_node | input | 2 | Consumer node code |
| alloc_valid | input | 1 | A reorder-buffer entry is reallocated |
| alloc_idx | input | IDX_W | Entry being reallocated |
| train_valid | output | 1 | One-cycle training strobe |
| train_pc | output | PC_W | PC of the judged instruction |
| train_critical | output | 1 | 1 if the token survived the window |

## Verification
The bench builds the block with ROB_DEPTH=16, NUM_TOKENS=2, WINDOW=32 and PC_W=16. The short window makes the exact expiry cycle, the one-cycle pulse and the return to idle quick to reach. Two lanes are enough to fill the block completely, reject a third plant, and show that tokens overlapping in time do not leak into each other. The 16-entry array allows propagation chains, overwrites of a consumer by a token-free producer, and a same-cycle collision between a reallocation and an edge write into the same entry.

// File: rtl/crit_token_pkg.sv
package crit_token_pkg;

  typedef enum logic [1:0] {
    NODE_F    = 2'd0,
    NODE_E    = 2'd1,
    NODE_C    = 2'd2,
    NODE_NONE = 2'd3
  } node_e;

  localparam int NODES_PER_ENTRY = 3;

  function automatic logic node_valid(input logic [1:0] code);
    return code != NODE_NONE;
  endfunction

  function automatic logic [NODES_PER_ENTRY-1:0] node_mask(input logic [1:0] code);
    logic [NODES_PER_ENTRY-1:0] m;
    m = '0;
    if (code != NODE_NONE) m[code] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/lane_picker.sv
module lane_picker #(
  parameter int NUM_LANES = 2
) (
  input  logic                 req,
  input  logic [NUM_LANES-1:0] busy,
  output logic [NUM_LANES-1:0] grant,
  output logic                 any_idle
);

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (!busy[i] && !found) begin
        found    = 1'b1;
        grant[i] = req;
      end
    end
    any_idle = found;
  end

endmodule

// File: rtl/token_lane.sv
module token_lane
  import crit_token_pkg::*;
#(
  parameter int ROB_DEPTH = 128,
  parameter int WINDOW    = 500,
  parameter int PC_W      = 32,
  localparam int IDX_W    = $clog2(ROB_DEPTH),
  localparam int CNT_W    = $clog2(WINDOW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             plant_go,
  input  logic [IDX_W-1:0] plant_idx,
  input  logic [1:0]       plant_node,
  input  logic [PC_W-1:0]  plant_pc,
  input  logic             edge_go,
  input  logic [IDX_W-1:0] e_src_idx,
  input  logic [1:0]       e_src_node,
  input  logic [IDX_W-1:0] e_dst_idx,
  input  logic [1:0]       e_dst_node,
  input  logic             clr_go,
  input  logic [IDX_W-1:0] clr_idx,
  output logic             busy_o,
  output logic             done_o,
  output logic             verdict_o,
  output logic [PC_W-1:0]  pc_o
);

  logic [NODES_PER_ENTRY-1:0] tok_q [ROB_DEPTH];
  logic [NODES_PER_ENTRY-1:0] tok_d [ROB_DEPTH];
  logic                       busy_q;
  logic [CNT_W-1:0]           cnt_q;
  logic [PC_W-1:0]            pc_q;
  logic                       expire;
  logic                       edge_wr;
  logic                       src_rd;
  logic                       alive;
  logic [NODES_PER_ENTRY-1:0] dmask;
  logic [NODES_PER_ENTRY-1:0] pmask;

  assign expire  = busy_q && (cnt_q == CNT_W'(WINDOW - 1));
  assign edge_wr = edge_go && busy_q && !expire;
  assign src_rd  = |(tok_q[e_src_idx] & node_mask(e_src_node));
  assign dmask   = node_mask(e_dst_node);
  assign pmask   = node_mask(plant_node);

  // next state of the token array: clear, then edge write, then plant
  always_comb begin
    for (int i = 0; i < ROB_DEPTH; i++) begin
      tok_d[i] = tok_q[i];
      if (expire) begin
        tok_d[i] = '0;
      end else begin
        if (clr_go && clr_idx == IDX_W'(i)) tok_d[i] = '0;
        if (edge_wr && e_dst_idx == IDX_W'(i))
          tok_d[i] = (tok_d[i] & ~dmask) | (src_rd ? dmask : '0);
        if (plant_go && plant_idx == IDX_W'(i)) tok_d[i] = tok_d[i] | pmask;
      end
    end
  end

  always_comb begin
    alive = 1'b0;
    for (int i = 0; i < ROB_DEPTH; i++) alive = alive | (|tok_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ROB_DEPTH; i++) tok_q[i] <= '0;
    end else begin
      for (int i = 0; i < ROB_DEPTH; i++) tok_q[i] <= tok_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pc_q   <= '0;
    end else if (plant_go && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      pc_q   <= plant_pc;
    end else if (busy_q) begin
      if (expire) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = expire;
  assign verdict_o = alive;
  assign pc_o      = pc_q;

  // R3: a consumer bit takes the producer bit read at the start of the cycle
  a_r3_edge_copies_producer: assert property (@(posedge clk) disable iff (rst)
    edge_wr |=> (|(tok_q[$past(e_dst_idx)] & node_mask($past(e_dst_node)))) == $past(src_rd));

  // R4: a reallocated entry is empty unless an edge or a plant wrote it in the same cycle
  a_r4_alloc_clears_entry: assert property (@(posedge clk) disable iff (rst)
    (clr_go && !(edge_wr && e_dst_idx == clr_idx) && !(plant_go && plant_idx == clr_idx))
      |=> tok_q[$past(clr_idx)] == '0);

  // R5: expiry lasts one cycle and leaves the lane idle
  a_r5_single_expiry: assert property (@(posedge clk) disable iff (rst)
    expire |=> !busy_q && !expire);

  // R6: a busy lane keeps its planted PC until expiry
  a_r6_pc_held: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !expire) |=> $stable(pc_q));

  // R8: after expiry no bit of the lane survives
  a_r8_lane_emptied: assert property (@(posedge clk) disable iff (rst)
    expire |=> !alive);

endmodule

// File: rtl/train_merge.sv
module train_merge #(
  parameter int NUM_LANES = 2,
  parameter int PC_W      = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_LANES-1:0]      done,
  input  logic [NUM_LANES-1:0]      verdict,
  input  logic [NUM_LANES*PC_W-1:0] pc_flat,
  output logic                      train_valid,
  output logic [PC_W-1:0]           train_pc,
  output logic                      train_critical
);

  logic [PC_W-1:0] pc_sel;
  logic            crit_sel;

  always_comb begin
    pc_sel   = '0;
    crit_sel = 1'b0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (done[i]) begin
        pc_sel   = pc_sel | pc_flat[i*PC_W +: PC_W];
        crit_sel = crit_sel | verdict[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      train_valid    <= 1'b0;
      train_pc       <= '0;
      train_critical <= 1'b0;
    end else begin
      train_valid    <= |done;
      train_pc       <= (|done) ? pc_sel : train_pc;
      train_critical <= (|done) ? crit_sel : train_critical;
    end
  end

  // R7: lanes expire on distinct cycles, so the merge never combines two verdicts
  a_r7_one_lane_done: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done));

endmodule

// File: rtl/crit_token_analyzer.sv
module crit_token_analyzer
  import crit_token_pkg::*;
#(
  parameter int ROB_DEPTH  = 128,
  parameter int NUM_TOKENS = 2,
  parameter int WINDOW     = 500,
  parameter int PC_W       = 32,
  localparam int IDX_W     = $clog2(ROB_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             plant_valid,
  input  logic [IDX_W-1:0] plant_idx,
  input  logic [1:0]       plant_node,
  input  logic [PC_W-1:0]  plant_pc,
  output logic             plant_ready,
  input  logic             edge_valid,
  input  logic [IDX_W-1:0] edge_src_idx,
  input  logic [1:0]       edge_src_node,
  input  logic [IDX_W-1:0] edge_dst_idx,
  input  logic [1:0]       edge_dst_node,
  input  logic             alloc_valid,
  input  logic [IDX_W-1:0] alloc_idx,
  output logic             train_valid,
  output logic [PC_W-1:0]  train_pc,
  output logic             train_critical
);

  logic                       plant_ok;
  logic                       edge_ok;
  logic [NUM_TOKENS-1:0]      lane_busy;
  logic [NUM_TOKENS-1:0]      lane_grant;
  logic [NUM_TOKENS-1:0]      lane_done;
  logic [NUM_TOKENS-1:0]      lane_verdict;
  logic [NUM_TOKENS*PC_W-1:0] lane_pc;

  assign plant_ok = plant_valid && node_valid(plant_node);
  assign edge_ok  = edge_valid && node_valid(edge_src_node) && node_valid(edge_dst_node);

  lane_picker #(.NUM_LANES(NUM_TOKENS)) picker_i (
    .req      (plant_ok),
    .busy     (lane_busy),
    .grant    (lane_grant),
    .any_idle (plant_ready)
  );

  for (genvar g = 0; g < NUM_TOKENS; g++) begin : g_lane
    token_lane #(
      .ROB_DEPTH (ROB_DEPTH),
      .WINDOW    (WINDOW),
      .PC_W      (PC_W)
    ) lane_i (
      .clk        (clk),
      .rst        (rst),
      .plant_go   (lane_grant[g]),
      .plant_idx  (plant_idx),
      .plant_node (plant_node),
      .plant_pc   (plant_pc),
      .edge_go    (edge_ok),
      .e_src_idx  (edge_src_idx),
      .e_src_node (edge_src_node),
      .e_dst_idx  (edge_dst_idx),
      .e_dst_node (edge_dst_node),
      .clr_go     (alloc_valid),
      .clr_idx    (alloc_idx),
      .busy_o     (lane_busy[g]),
      .done_o     (lane_done[g]),
      .verdict_o  (lane_verdict[g]),
      .pc_o       (lane_pc[g*PC_W +: PC_W])
    );
  end

  train_merge #(.NUM_LANES(NUM_TOKENS), .PC_W(PC_W)) merge_i (
    .clk            (clk),
    .rst            (rst),
    .done           (lane_done),
    .verdict        (lane_verdict),
    .pc_flat        (lane_pc),
    .train_valid    (train_valid),
    .train_pc       (train_pc),
    .train_critical (train_critical)
  );

  // R2: an accepted plant makes some lane busy on the next cycle
  a_r2_plant_takes_lane: assert property (@(posedge clk) disable iff (rst)
    (plant_ok && plant_ready) |=> (lane_busy != '0));

  // R6: with every lane busy, no lane is granted
  a_r6_full_rejects: assert property (@(posedge clk) disable iff (rst)
    (&lane_busy) |-> (lane_grant == '0));

endmodule

// File: tb/crit_token_analyzer_tb_top.sv
`timescale 1ns/1ps
module crit_token_analyzer_tb_top;

  localparam int ROB   = 16;
  localparam int NT    = 2;
  localparam int WIN   = 32;
  localparam int PCW   = 16;
  localparam int IW    = $clog2(ROB);

  logic           clk = 1'b0;
  logic           rst;
  logic           plant_valid;
  logic [IW-1:0]  plant_idx;
  logic [1:0]     plant_node;
  logic [PCW-1:0] plant_pc;
  logic           plant_ready;
  logic           edge_valid;
  logic [IW-1:0]  edge_src_idx;
  logic [1:0]     edge_src_node;
  logic [IW-1:0]  edge_dst_idx;
  logic [1:0]     edge_dst_node;
  logic           alloc_valid;
  logic [IW-1:0]  alloc_idx;
  logic           train_valid;
  logic [PCW-1:0] train_pc;
  logic           train_critical;

  always #2.5 clk = ~clk;

  crit_token_analyzer #(.ROB_DEPTH(ROB), .NUM_TOKENS(NT), .WINDOW(WIN), .PC_W(PCW)) dut_i (
    .clk, .rst, .plant_valid, .plant_idx, .plant_node, .plant_pc, .plant_ready,
    .edge_valid, .edge_src_idx, .edge_src_node, .edge_dst_idx, .edge_dst_node,
    .alloc_valid, .alloc_idx, .train_valid, .train_pc, .train_critical
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int n_pulse = 0;
  int rec_cyc  [8];
  int rec_pc   [8];
  int rec_crit [8];
  int last_plant = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (train_valid && n_pulse < 8) begin
      rec_cyc[n_pulse]  = cyc;
      rec_pc[n_pulse]   = int'(train_pc);
      rec_crit[n_pulse] = int'(train_critical);
    end
    if (train_valid) n_pulse = n_pulse + 1;
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    plant_valid = 0; plant_idx = '0; plant_node = 2'd0; plant_pc = '0;
    edge_valid = 0; edge_src_idx = '0; edge_src_node = 2'd0;
    edge_dst_idx = '0; edge_dst_node = 2'd0;
    alloc_valid = 0; alloc_idx = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_plant(input int idx, input int node, input int pc);
    plant_valid = 1; plant_idx = IW'(idx); plant_node = 2'(node); plant_pc = PCW'(pc);
    @(negedge clk);
    plant_valid = 0;
    last_plant = cyc;
  endtask

  task automatic do_edge(input int si, input int sn, input int di, input int dn);
    edge_valid = 1; edge_src_idx = IW'(si); edge_src_node = 2'(sn);
    edge_dst_idx = IW'(di); edge_dst_node = 2'(dn);
    @(negedge clk);
    edge_valid = 0;
  endtask

  task automatic do_alloc(input int idx);
    alloc_valid = 1; alloc_idx = IW'(idx);
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic expect_pulse(input int k, input int exp_cyc, input int pc, input int crit,
                              input string tag);
    check(n_pulse > k, {tag, " pulse seen"}, n_pulse, k + 1);
    if (n_pulse > k) begin
      check(rec_cyc[k] == exp_cyc, {tag, " R5 pulse cycle"}, rec_cyc[k], exp_cyc);
      check(rec_pc[k] == pc, {tag, " R5 pc"}, rec_pc[k], pc);
      check(rec_crit[k] == crit, {tag, " verdict"}, rec_crit[k], crit);
    end
  endtask

  task automatic t_reset();
    check(plant_ready == 1'b1, "R1 ready after reset", int'(plant_ready), 1);
    check(train_valid == 1'b0, "R1 no strobe after reset", int'(train_valid), 0);
  endtask

  task automatic t_dies_on_alloc();
    int p;
    n_pulse = 0;
    do_plant(2, 1, 16'h1111);
    p = last_plant;
    do_alloc(2);
    wait_cyc(WIN + 2);
    expect_pulse(0, p + WIN, 16'h1111, 0, "R4 killed token");
    check(n_pulse == 1, "R5 pulse is one cycle", n_pulse, 1);
    check(plant_ready == 1'b1, "R8 ready after verdict", int'(plant_ready), 1);
  endtask

  task automatic t_chain_survives();
    int p;
    n_pulse = 0;
    do_plant(3, 1, 16'h2222);
    p = last_plant;
    do_edge(3, 1, 4, 1);
    do_edge(4, 1, 5, 2);
    do_alloc(3);
    do_alloc(4);
    wait_cyc(WIN);
    expect_pulse(0, p + WIN, 16'h2222, 1, "R3 chain survives");
  endtask

  task automatic t_overwrite_kills();
    int p;
    n_pulse = 0;
    do_plant(6, 0, 16'h3333);
    p = last_plant;
    do_edge(6, 0, 9, 1);
    do_edge(10, 1, 9, 1);
    do_alloc(6);
    wait_cyc(WIN);
    expect_pulse(0, p + WIN, 16'h3333, 0, "R3 token-free producer clears consumer");
  endtask

  task automatic t_invalid_codes();
    int p;
    n_pulse = 0;
    do_plant(7, 3, 16'h4444);
    check(plant_ready == 1'b1, "R2 code-3 plant ignored (ready)", int'(plant_ready), 1);
    wait_cyc(WIN + 3);
    check(n_pulse == 0, "R2 code-3 plant gives no strobe", n_pulse, 0);
    do_plant(1, 0, 16'h5555);
    p = last_plant;
    do_edge(1, 0, 2, 3);
    do_edge(1, 3, 2, 1);
    do_alloc(1);
    wait_cyc(WIN);
    expect_pulse(0, p + WIN, 16'h5555, 0, "R3 code-3 edge ignored");
  endtask

  task automatic t_two_lanes();
    int pa, pb;
    n_pulse = 0;
    do_plant(2, 1, 16'hAAAA);
    pa = last_plant;
    do_plant(12, 1, 16'hBBBB);
    pb = last_plant;
    check(plant_ready == 1'b0, "R6 not ready when full", int'(plant_ready), 0);
    do_plant(14, 2, 16'hCCCC);
    do_edge(2, 1, 3, 1);
    do_alloc(2);
    do_alloc(12);
    wait_cyc(WIN + 2);
    expect_pulse(0, pa + WIN, 16'hAAAA, 1, "R7 lane A survives");
    expect_pulse(1, pb + WIN, 16'hBBBB, 0, "R7 lane B dies");
    check(n_pulse == 2, "R6 third plant ignored", n_pulse, 2);
    check(plant_ready == 1'b1, "R8 ready after both verdicts", int'(plant_ready), 1);
    do_alloc(3);
  endtask

  task automatic t_edge_beats_alloc();
    int p;
    n_pulse = 0;
    do_plant(4, 1, 16'h6666);
    p = last_plant;
    edge_valid = 1; edge_src_idx = 4'd4; edge_src_node = 2'd1;
    edge_dst_idx = 4'd5; edge_dst_node = 2'd0;
    alloc_valid = 1; alloc_idx = 4'd5;
    @(negedge clk);
    edge_valid = 0; alloc_valid = 0;
    do_alloc(4);
    wait_cyc(WIN);
    expect_pulse(0, p + WIN, 16'h6666, 1, "R4 edge wins over same-cycle alloc");
  endtask

  task automatic t_fresh_after_verdict();
    int p;
    n_pulse = 0;
    do_plant(8, 2, 16'h7777);
    wait_cyc(WIN + 2);
    expect_pulse(0, last_plant + WIN, 16'h7777, 1, "R5 untouched token survives");
    do_plant(0, 0, 16'h7778);
    p = last_plant;
    do_alloc(0);
    wait_cyc(WIN + 2);
    expect_pulse(1, p + WIN, 16'h7778, 0, "R8 old bits cleared at expiry");
    do_plant(0, 0, 16'h0);
    do_alloc(0);
    wait_cyc(WIN + 2);
  endtask

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    wait_cyc(4);
    rst = 0;
    wait_cyc(1);
    t_reset();
    t_dies_on_alloc();
    t_chain_survives();
    t_overwrite_kills();
    t_invalid_codes();
    t_two_lanes();
    t_edge_beats_alloc();
    t_fresh_after_verdict();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule